// File: doc/BRIEF.md
# Pollable Priority Interrupt Controller

This block gathers eight interrupt request lines, resolves them by fixed priority, and raises a single interrupt output toward a processor. Each line can sense either rising edges or a high level, chosen through a trigger-mode register. The three highest-priority lines are locked to edge sensing. Software works the block through a small byte-wide register port. The port has a command address for control words and end-of-interrupt, a status address for readback, and a trigger-mode address.

Status reads return either the pending-request register or the in-service register, as chosen by a sticky selector in the control word. Software can also arm a poll. The next status read then acts as an acknowledge: it returns an encoded byte that names the highest-priority pending line, and it moves that line into service. A non-specific end-of-interrupt command retires the highest-priority line in service.

Top module: `pic_poll_ctrl`

## Requirements
- R1: After reset the trigger-mode register reads 00h, the request and in-service registers are empty, status reads return the request register, and int_out is 0.
- R2: A line in edge mode (trigger bit 0) sets its request bit on a low-to-high input transition. The bit stays set after the input falls, until a poll acknowledge clears it.
- R3: For a line in level mode (trigger bit 1), the request bit follows the input level, so dropping the input withdraws the request.
- R4: Trigger-mode bits 2:0 always read 0, and any ones written to them are dropped. Bits 7:3 are read/write. The register sits at address 2.
- R5: A command write (address 0) with bits 4:3 = 01 is a control word. If its bit 1 is 1, bit 0 selects the status readback (0 = request register, 1 = in-service register). If bit 1 is 0, the selection stays as it was.
- R6: The selected register can be read at the status address (address 1) any number of times without another command write.
- R7: A control word with bit 2 = 1 arms a poll. The next status read returns {any pending, 4'b0000, index of highest-priority pending line}, where line 0 has the highest priority.
- R8: A poll acknowledge sets the chosen line's in-service bit and clears its edge latch. It also disarms the poll, so the following status read returns the selected register again.
- R9: int_out is 1 exactly when some request is pending whose line index is lower than every line in service.
- R10: A command write with bits 4:3 = 00 and bit 5 = 1 clears the lowest-indexed set bit of the in-service register.
- R11: A poll acknowledge with no request pending returns 00h and leaves the in-service register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Interrupt request lines, bit i is line i |
| cs | input | 1 | Register port select |
| addr | input | 2 | 0 command, 1 status, 2 trigger mode |
| rd | input | 1 | Read strobe, one cycle per access |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while cs and rd are high |
| int_out | output | 1 | Interrupt request to the processor |

## Verification
Directed sequences first separate edge lines from level lines. A pulse that has already fallen must still show as pending on an edge line, and a dropped level must vanish. Nested service then checks that a lower-priority request is held off while a higher-priority one is blocked by nothing. Polls are tried with several lines pending, with none pending, and back to back, to tell the acknowledge byte apart from plain readback and to confirm that the poll disarms. Random mixes of line toggles, control words, end-of-interrupt writes and reads are then compared against a bench model every cycle.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    PORT_CMD  = 2'd0,
    PORT_STAT = 2'd1,
    PORT_TRIG = 2'd2
  } port_addr_e;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_CTRL,
    CMD_EOI
  } cmd_kind_e;

  function automatic cmd_kind_e decode_cmd(input logic [7:0] b);
    if (b[4:3] == 2'b01) return CMD_CTRL;
    if (b[4:3] == 2'b00 && b[5]) return CMD_EOI;
    return CMD_NONE;
  endfunction
endpackage

// File: rtl/pic_req_line.sv
module pic_req_line (
  input  logic clk,
  input  logic rst_n,
  input  logic irq,
  input  logic level,
  input  logic ack_clr,
  output logic req,
  output logic rise
);
  logic irq_q;
  logic latch_q;

  assign rise = irq & ~irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q   <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      irq_q   <= irq;
      latch_q <= (latch_q & ~ack_clr) | rise;
    end
  end

  assign req = level ? irq : latch_q;

  a_r2_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && !level) |=> (req || level));
  a_r2_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!level && req && !ack_clr) |=> (req || level));
endmodule

// File: rtl/pic_prio_res.sv
module pic_prio_res #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irr,
  input  logic [N-1:0]  isr,
  output logic          req_any,
  output logic [IW-1:0] req_idx,
  output logic          isr_any,
  output logic [IW-1:0] isr_idx,
  output logic          int_req
);
  function automatic logic [IW:0] first_set(input logic [N-1:0] v);
    logic [IW:0] r;
    r = {1'b0, {IW{1'b0}}};
    for (int i = N - 1; i >= 0; i--)
      if (v[i]) r = {1'b1, IW'(i)};
    return r;
  endfunction

  logic [IW:0] req_f, isr_f;
  assign req_f   = first_set(irr);
  assign isr_f   = first_set(isr);
  assign req_any = req_f[IW];
  assign req_idx = req_f[IW-1:0];
  assign isr_any = isr_f[IW];
  assign isr_idx = isr_f[IW-1:0];
  assign int_req = req_any && (!isr_any || (req_idx < isr_idx));

  a_r9_int_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> (irr != '0));
  a_r7_idx_is_set: assert property (@(posedge clk) disable iff (!rst_n)
    req_any |-> irr[req_idx]);
endmodule

// File: rtl/pic_poll_ctrl.sv
module pic_poll_ctrl
  import pic_pkg::*;
#(
  parameter int N          = 8,
  parameter int DW         = 8,
  parameter int EDGE_LINES = 3,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  irq_in,
  input  logic          cs,
  input  logic [1:0]    addr,
  input  logic          rd,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          int_out
);
  localparam logic [N-1:0] TRIG_MASK = ~((N)'((1 << EDGE_LINES) - 1));

  logic [N-1:0]  trig_q, isr_q, irr, ack_clr;
  logic          sel_isr_q, poll_q;
  logic          req_any, isr_any;
  logic [IW-1:0] req_idx, isr_idx;
  cmd_kind_e     cmd;

  // named events
  logic cmd_wr, trig_wr, stat_rd, poll_ack, ack_fire, eoi_fire;
  assign cmd      = decode_cmd(wdata[7:0]);
  assign cmd_wr   = cs && wr && (addr == PORT_CMD);
  assign trig_wr  = cs && wr && (addr == PORT_TRIG);
  assign stat_rd  = cs && rd && (addr == PORT_STAT);
  assign poll_ack = stat_rd && poll_q;
  assign ack_fire = poll_ack && req_any;
  assign eoi_fire = cmd_wr && (cmd == CMD_EOI) && isr_any;

  for (genvar g = 0; g < N; g++) begin : g_line
    assign ack_clr[g] = ack_fire && (req_idx == IW'(g));
    pic_req_line u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .irq    (irq_in[g]),
      .level  (trig_q[g]),
      .ack_clr(ack_clr[g]),
      .req    (irr[g]),
      .rise   ()
    );
  end

  pic_prio_res #(.N(N)) u_res (
    .clk    (clk),
    .rst_n  (rst_n),
    .irr    (irr),
    .isr    (isr_q),
    .req_any(req_any),
    .req_idx(req_idx),
    .isr_any(isr_any),
    .isr_idx(isr_idx),
    .int_req(int_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trig_q    <= '0;
      isr_q     <= '0;
      sel_isr_q <= 1'b0;
      poll_q    <= 1'b0;
    end else begin
      if (trig_wr) trig_q <= wdata[N-1:0] & TRIG_MASK;
      if (cmd_wr && cmd == CMD_CTRL) begin
        if (wdata[1]) sel_isr_q <= wdata[0];
        if (wdata[2]) poll_q <= 1'b1;
      end
      if (poll_ack) poll_q <= 1'b0;
      if (ack_fire) isr_q[req_idx] <= 1'b1;
      if (eoi_fire) isr_q[isr_idx] <= 1'b0;
    end
  end

  logic [DW-1:0] poll_byte;
  always_comb begin
    poll_byte = '0;
    poll_byte[DW-1] = req_any;
    poll_byte[IW-1:0] = req_idx;
  end

  always_comb begin
    rdata = '0;
    if (cs && rd) begin
      if (addr == PORT_STAT)
        rdata = poll_q ? poll_byte : DW'(sel_isr_q ? isr_q : irr);
      else if (addr == PORT_TRIG)
        rdata = DW'(trig_q);
    end
  end

  a_r4_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q & ~TRIG_MASK) == '0);
  a_r5_sel_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && !wdata[1]) |=> $stable(sel_isr_q));
  a_r8_poll_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    poll_ack |=> !poll_q);
  a_r8_ack_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
    ack_fire |=> isr_q[$past(req_idx)]);
  a_r10_eoi_one: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_fire |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));
  a_r11_empty_poll: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_ack && !req_any) |=> $stable(isr_q));
endmodule

// File: tb/tb_pic_poll_ctrl.sv
module tb_pic_poll_ctrl;
  localparam int PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic [7:0] irq_in = 0, wdata = 0;
  logic       cs = 0, rd = 0, wr = 0;
  logic [1:0] addr = 0;
  logic [7:0] rdata;
  logic       int_out;

  int tests = 0, fails = 0;
  bit done = 0;

  pic_poll_ctrl dut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cs(cs), .addr(addr),
    .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata), .int_out(int_out));

  always #(PERIOD/2) clk = ~clk;

  // bench model
  logic [7:0] m_trig, m_latch, m_isr, m_prev;
  logic       m_sel, m_poll;

  function automatic int low_bit(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 8;
  endfunction
  function automatic logic [7:0] m_irr();
    return (m_trig & irq_in) | (~m_trig & m_latch);
  endfunction
  function automatic logic m_int();
    return (m_irr() != 0) && (low_bit(m_irr()) < low_bit(m_isr));
  endfunction
  function automatic logic [7:0] m_stat();
    if (m_poll) return (m_irr() == 0) ? 8'h00 : (8'h80 | 8'(low_bit(m_irr())));
    return m_sel ? m_isr : m_irr();
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_trig = 0; m_latch = 0; m_isr = 0; m_prev = 0; m_sel = 0; m_poll = 0;
    end else begin
      logic [7:0] irr_v, clr;
      irr_v = m_irr(); clr = 0;
      if (cs && rd && addr == 2'd1 && m_poll) begin
        m_poll = 0;
        if (irr_v != 0) begin
          m_isr[low_bit(irr_v)] = 1'b1;
          clr[low_bit(irr_v)] = 1'b1;
        end
      end
      if (cs && wr && addr == 2'd2) m_trig = wdata & 8'hF8;
      if (cs && wr && addr == 2'd0) begin
        if (wdata[4:3] == 2'b01) begin
          if (wdata[1]) m_sel = wdata[0];
          if (wdata[2]) m_poll = 1;
        end else if (wdata[4:3] == 2'b00 && wdata[5] && m_isr != 0)
          m_isr[low_bit(m_isr)] = 1'b0;
      end
      m_latch = (m_latch & ~clr) | (irq_in & ~m_prev);
      m_prev = irq_in;
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // one bus cycle: drive at negedge, check after settling
  task automatic cyc(input logic c, input logic [1:0] a, input logic r, input logic w,
                     input logic [7:0] d, input logic [7:0] irq, input string tag);
    @(negedge clk);
    cs = c; addr = a; rd = r; wr = w; wdata = d; irq_in = irq;
    #1;
    if (c && r) check(tag, rdata, (a == 2'd1) ? m_stat() : (a == 2'd2) ? m_trig : 8'h00);
    check({tag, "/R9 int"}, {7'd0, int_out}, {7'd0, m_int()});
  endtask

  task automatic dchk(input string tag, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk);
    cs = 1; addr = a; rd = 1; wr = 0;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic wr_(input logic [1:0] a, input logic [7:0] d);
    cyc(1, a, 0, 1, d, irq_in, "wr");
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1
    dchk("R1 status", 2'd1, 8'h00);
    dchk("R1 trig", 2'd2, 8'h00);
    check("R1 int_out", {7'd0, int_out}, 8'h00);
    // R4
    wr_(2'd2, 8'hFF);
    dchk("R4 trig locked", 2'd2, 8'hF8);
    wr_(2'd2, 8'h10);
    dchk("R4 trig rw", 2'd2, 8'h10);
    // R2 edge pulse on line 5
    cyc(0, 0, 0, 0, 0, 8'h20, "R2 raise");
    cyc(0, 0, 0, 0, 0, 8'h00, "R2 drop");
    dchk("R2 latched", 2'd1, 8'h20);
    check("R9 int pending", {7'd0, int_out}, 8'h01);
    // R3 level on line 4
    cyc(0, 0, 0, 0, 0, 8'h10, "R3 raise");
    dchk("R3 level on", 2'd1, 8'h30);
    cyc(0, 0, 0, 0, 0, 8'h00, "R3 drop");
    dchk("R3 withdrawn", 2'd1, 8'h20);
    // R7 / R8
    wr_(2'd0, 8'h0C);
    dchk("R7 poll byte", 2'd1, 8'h85);
    wr_(2'd0, 8'h0B);
    dchk("R8 isr set", 2'd1, 8'h20);
    dchk("R6 repeat read", 2'd1, 8'h20);
    wr_(2'd0, 8'h08);
    dchk("R5 kept", 2'd1, 8'h20);
    wr_(2'd0, 8'h0A);
    dchk("R8 latch cleared", 2'd1, 8'h00);
    // R9 nesting
    cyc(0, 0, 0, 0, 0, 8'h40, "R9 l6");
    cyc(0, 0, 0, 0, 0, 8'h00, "R9 l6");
    check("R9 lower blocked", {7'd0, int_out}, 8'h00);
    cyc(0, 0, 0, 0, 0, 8'h08, "R9 l3");
    cyc(0, 0, 0, 0, 0, 8'h00, "R9 l3");
    check("R9 higher wins", {7'd0, int_out}, 8'h01);
    // R10
    wr_(2'd0, 8'h0B);
    wr_(2'd0, 8'h0C);
    dchk("R7 poll l3", 2'd1, 8'h83);
    dchk("R8 poll disarmed", 2'd1, 8'h28);
    wr_(2'd0, 8'h20);
    dchk("R10 eoi top", 2'd1, 8'h20);
    wr_(2'd0, 8'h20);
    dchk("R10 eoi next", 2'd1, 8'h00);
    // R11
    wr_(2'd0, 8'h0C);
    dchk("R7 poll l6", 2'd1, 8'h86);
    wr_(2'd0, 8'h0C);
    dchk("R11 empty poll", 2'd1, 8'h00);
    dchk("R11 isr kept", 2'd1, 8'h40);
    wr_(2'd0, 8'h20);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [7:0] irq_v, d;
      op = $urandom_range(0, 9);
      irq_v = irq_in;
      if ($urandom_range(0, 3) == 0) irq_v[$urandom_range(0, 7)] ^= 1'b1;
      d = 8'($urandom);
      case (op)
        0, 1: cyc(1, 2'd1, 1, 0, 0, irq_v, "R5/R7 rand status");
        2:    cyc(1, 2'd2, 1, 0, 0, irq_v, "R4 rand trig");
        3:    cyc(1, 2'd0, 0, 1, {3'b000, 2'b01, d[2:0]}, irq_v, "R5 rand ctrl");
        4:    cyc(1, 2'd0, 0, 1, 8'h20, irq_v, "R10 rand eoi");
        5:    cyc(1, 2'd2, 0, 1, d, irq_v, "R4 rand trig wr");
        6:    cyc(1, 2'd0, 0, 1, d, irq_v, "R10 rand cmd");
        default: cyc(0, 2'd0, 0, 0, 0, irq_v, "R2/R3 rand idle");
      endcase
    end
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule